// File: doc/BRIEF.md
# Register-Bus SPI Master

This block is an SPI master that a processor drives through six 32-bit word registers on a simple synchronous bus. Writing a byte to the transmit register places it in a one-byte holding register. The shift engine then moves it into its shift register and sends it as one 8-bit frame, most significant bit first, in SPI mode 0. At the same time it collects the byte returned on the serial input. When the frame ends, the returned byte waits in the receive register until software reads it.

Status flags report whether the holding register can take a byte, whether the whole transmit path is empty, and whether a received byte is waiting. Two sticky overrun flags and their summary report lost data. Each of these flags can drive the interrupt line through its own enable bit. A one-hot select register picks among up to 32 active-low chip-select lines. A hold bit in the control register keeps the chosen line asserted across frames. The serial clock half period is a build-time parameter, measured in system clock cycles.

Top module: `spi_host_ctrl`

## Requirements
- R1: Word addresses: 0 receive data (read), 1 transmit data (write, reads 0), 2 status, 3 control, 4 reserved (reads 0, writes ignored), 5 slave select. Control keeps only bits 3, 4, 6, 7, 8 and 10 of a write (mask 0x5D8). Slave select reads back the value written.
- R2: A transmit write accepted while TRDY is high sends exactly 8 bits, MSB first. SCLK idles low. MOSI changes only while SCLK is low, and MISO is sampled as SCLK rises. Each SCLK half period lasts CLK_DIV clock cycles.
- R3: RRDY (status bit 7) sets when a frame completes. The received byte reads at address 0 in bits 7:0, and that read clears RRDY.
- R4: ROE (status bit 3) sets when a frame completes while RRDY is still set and not being read. The new byte replaces the old one.
- R5: TRDY (status bit 6) is high while the holding register is empty. A transmit write while TRDY is low sets TOE (status bit 4), and its data is discarded.
- R6: TMT (status bit 5) is high only when neither the holding register nor the shift register holds a byte.
- R7: Any write to the status address clears ROE and TOE. E (status bit 8) equals ROE OR TOE.
- R8: irq is the OR, over ROE, TOE, TRDY, RRDY and E, of each flag ANDed with the control bit at the same position.
- R9: ss_n[n] is low for each set select bit n while a frame shifts. With control bit 10 set, it stays low continuously, including idle time. With select zero, no line is low.
- R10: Without control bit 10, every chip-select line returns high for at least one cycle between back-to-back frames.
- R11: After reset, status reads 0x60, control and select read 0, all ss_n are high, SCLK is low and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects on receive data) |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data, combinational from address |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low chip selects |

## Verification
Frames are sent with complementary and asymmetric byte pairs on MOSI and MISO (A5/5A, 00/FF, FF/00, 80/01, 01/80, 3C/C3). These pairs expose bit-order reversal, a stuck serial line, or a transmit/receive mix-up. Back-to-back frames are sent once with the hold bit clear and once with it set. Counting chip-select falling edges then separates per-frame release from a held select. Writes into a full holding register, and frames that complete over an unread byte, check that the sticky overrun flags set, that the right byte survives each case, and that status writes clear the flags.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
   localparam int FRAME_W = 8;
   localparam int REG_AW  = 3;

   localparam logic [REG_AW-1:0] A_RXD  = 3'd0;
   localparam logic [REG_AW-1:0] A_TXD  = 3'd1;
   localparam logic [REG_AW-1:0] A_STAT = 3'd2;
   localparam logic [REG_AW-1:0] A_CTRL = 3'd3;
   localparam logic [REG_AW-1:0] A_RSVD = 3'd4;
   localparam logic [REG_AW-1:0] A_SSEL = 3'd5;

   localparam int B_ROE  = 3;
   localparam int B_TOE  = 4;
   localparam int B_TMT  = 5;
   localparam int B_TRDY = 6;
   localparam int B_RRDY = 7;
   localparam int B_ERR  = 8;
   localparam int B_HOLD = 10;
   localparam int CTRL_W = 11;

   localparam logic [CTRL_W-1:0] CTRL_MASK = 11'h5D8;
endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
   import spi_host_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int NUM_SS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [BUS_W-1:0]    reg_wdata,
   output logic [BUS_W-1:0]    reg_rdata,
   output logic                tx_full,
   output logic [FRAME_W-1:0]  tx_byte,
   input  logic                take,
   input  logic                busy,
   input  logic                done,
   input  logic [FRAME_W-1:0]  rx_in,
   output logic                rrdy,
   output logic                roe,
   output logic                toe,
   output logic                sso,
   output logic [NUM_SS-1:0]   ss_sel,
   output logic                irq
);
   logic [FRAME_W-1:0] hold_q, rx_q;
   logic               full_q, rrdy_q, roe_q, toe_q;
   logic [CTRL_W-1:0]  ctrl_q, stat_w;
   logic [NUM_SS-1:0]  sel_q;
   logic               wr_tx, wr_st, wr_ctl, wr_sel, rd_rx;
   logic               unused_wd;

   assign wr_tx  = reg_wr && (reg_addr == A_TXD);
   assign wr_st  = reg_wr && (reg_addr == A_STAT);
   assign wr_ctl = reg_wr && (reg_addr == A_CTRL);
   assign wr_sel = reg_wr && (reg_addr == A_SSEL);
   assign rd_rx  = reg_rd && (reg_addr == A_RXD);
   assign unused_wd = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
         toe_q  <= 1'b0;
      end else begin
         if (wr_tx && !full_q) begin
            hold_q <= reg_wdata[FRAME_W-1:0];
            full_q <= 1'b1;
         end else if (take) begin
            full_q <= 1'b0;
         end
         if (wr_tx && full_q)
            toe_q <= 1'b1;
         else if (wr_st)
            toe_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q   <= '0;
         rrdy_q <= 1'b0;
         roe_q  <= 1'b0;
      end else begin
         if (done) begin
            rx_q   <= rx_in;
            rrdy_q <= 1'b1;
         end else if (rd_rx) begin
            rrdy_q <= 1'b0;
         end
         if (done && rrdy_q && !rd_rx)
            roe_q <= 1'b1;
         else if (wr_st)
            roe_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         sel_q  <= '0;
      end else begin
         if (wr_ctl)
            ctrl_q <= reg_wdata[CTRL_W-1:0] & CTRL_MASK;
         if (wr_sel)
            sel_q <= reg_wdata[NUM_SS-1:0];
      end
   end

   always_comb begin
      stat_w         = '0;
      stat_w[B_ROE]  = roe_q;
      stat_w[B_TOE]  = toe_q;
      stat_w[B_TMT]  = !full_q && !busy;
      stat_w[B_TRDY] = !full_q;
      stat_w[B_RRDY] = rrdy_q;
      stat_w[B_ERR]  = roe_q || toe_q;
   end

   always_comb begin
      unique case (reg_addr)
         A_RXD:   reg_rdata = BUS_W'(rx_q);
         A_STAT:  reg_rdata = BUS_W'(stat_w);
         A_CTRL:  reg_rdata = BUS_W'(ctrl_q);
         A_SSEL:  reg_rdata = BUS_W'(sel_q);
         default: reg_rdata = '0;
      endcase
   end

   assign irq     = |(stat_w & ctrl_q);
   assign tx_full = full_q;
   assign tx_byte = hold_q;
   assign rrdy    = rrdy_q;
   assign roe     = roe_q;
   assign toe     = toe_q;
   assign sso     = ctrl_q[B_HOLD];
   assign ss_sel  = sel_q;
endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift
   import spi_host_pkg::*;
#(
   parameter int CLK_DIV = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_full,
   input  logic [FRAME_W-1:0] tx_byte,
   output logic               take,
   output logic               busy,
   output logic               done,
   output logic [FRAME_W-1:0] rx_byte,
   output logic               sclk,
   output logic               mosi,
   input  logic               miso
);
   localparam int BW = $clog2(FRAME_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

   logic               busy_q, sclk_q, done_q, tick;
   logic [BW-1:0]      bit_q;
   logic [FRAME_W-1:0] tx_sr, rx_sr;

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = busy_q;
      end else begin : g_div
         localparam int CW = $clog2(CLK_DIV);
         localparam logic [CW-1:0] CMAX = CW'(CLK_DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!busy_q || cnt_q == CMAX)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
         assign tick = busy_q && (cnt_q == CMAX);
      end
   endgenerate

   assign take = !busy_q && tx_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
         bit_q  <= '0;
         tx_sr  <= '0;
         rx_sr  <= '0;
      end else begin
         done_q <= 1'b0;
         if (take) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            bit_q  <= '0;
            tx_sr  <= tx_byte;
         end else if (tick) begin
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rx_sr  <= {rx_sr[FRAME_W-2:0], miso};
            end else begin
               sclk_q <= 1'b0;
               if (bit_q == LAST_BIT) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign rx_byte = rx_sr;
   assign sclk    = sclk_q;
   assign mosi    = busy_q && tx_sr[FRAME_W-1];
endmodule

// File: rtl/spi_host_csel.sv
module spi_host_csel #(
   parameter int NUM_SS = 32
) (
   input  logic              busy,
   input  logic              sso,
   input  logic [NUM_SS-1:0] ss_sel,
   output logic [NUM_SS-1:0] ss_n
);
   logic active;
   assign active = busy || sso;

   generate
      for (genvar i = 0; i < NUM_SS; i++) begin : g_line
         assign ss_n[i] = !(ss_sel[i] && active);
      end
   endgenerate
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
   import spi_host_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int NUM_SS  = 32,
   parameter int CLK_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic              irq,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_SS-1:0] ss_n
);
   generate
      if (NUM_SS < 1 || NUM_SS > 32) begin : g_bad_ss
         $error("NUM_SS must lie in 1..32");
      end
      if (BUS_W < CTRL_W || BUS_W < NUM_SS) begin : g_bad_bus
         $error("BUS_W too narrow for control or select fields");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
   endgenerate

   logic               tx_full, take, busy, done, rrdy, roe, toe, sso;
   logic [FRAME_W-1:0] tx_byte, rx_byte;
   logic [NUM_SS-1:0]  ss_sel;

   spi_host_regs #(.BUS_W(BUS_W), .NUM_SS(NUM_SS)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_full(tx_full), .tx_byte(tx_byte), .take(take),
      .busy(busy), .done(done), .rx_in(rx_byte),
      .rrdy(rrdy), .roe(roe), .toe(toe),
      .sso(sso), .ss_sel(ss_sel), .irq(irq)
   );

   spi_host_shift #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .tx_full(tx_full), .tx_byte(tx_byte), .take(take),
      .busy(busy), .done(done), .rx_byte(rx_byte),
      .sclk(sclk), .mosi(mosi), .miso(miso)
   );

   spi_host_csel #(.NUM_SS(NUM_SS)) u_csel (
      .busy(busy), .sso(sso), .ss_sel(ss_sel), .ss_n(ss_n)
   );
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk
   import spi_host_pkg::*;
#(
   parameter int NUM_SS = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic              tx_full,
   input logic              busy,
   input logic              done,
   input logic              rrdy,
   input logic              roe,
   input logic              toe,
   input logic              sclk,
   input logic              mosi,
   input logic              sso,
   input logic [NUM_SS-1:0] ss_n
);
   p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sclk && $past(sclk)) |-> $stable(mosi));

   p_rx_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_RXD && !done) |=> !rrdy);

   p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rrdy && !(reg_rd && reg_addr == A_RXD)) |=> roe);

   p_tx_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_TXD && tx_full) |=> toe);

   p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_STAT && !done) |=> (!roe && !toe));

   p_cs_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !sso) |-> (&ss_n));
endmodule

bind spi_host_ctrl spi_host_chk #(.NUM_SS(NUM_SS)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_rd(reg_rd), .tx_full(tx_full), .busy(busy), .done(done),
   .rrdy(rrdy), .roe(roe), .toe(toe), .sclk(sclk), .mosi(mosi),
   .sso(sso), .ss_n(ss_n)
);

// File: tb/sim_spi_host_ctrl.sv
`timescale 1ns/1ps
module sim_spi_host_ctrl;
   localparam int BUS_W   = 32;
   localparam int NUM_SS  = 32;
   localparam int CLK_DIV = 2;
   localparam int NVEC    = 6;
   // upper byte: sent on mosi, lower byte: returned on miso
   localparam logic [15:0] VEC [0:NVEC-1] = '{
      16'hA55A, 16'h00FF, 16'hFF00, 16'h8001, 16'h0180, 16'h3CC3
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        reg_addr = '0;
   logic              reg_wr = 1'b0;
   logic              reg_rd = 1'b0;
   logic [BUS_W-1:0]  reg_wdata = '0;
   logic [BUS_W-1:0]  reg_rdata;
   logic              irq, sclk, mosi, miso;
   logic [NUM_SS-1:0] ss_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   spi_host_ctrl #(.BUS_W(BUS_W), .NUM_SS(NUM_SS), .CLK_DIV(CLK_DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   // serial slave model
   logic [7:0] slave_byte = 8'h00;
   logic [7:0] mosi_cap = 8'h00;
   logic [2:0] rise_cnt = 3'd0;
   always @(posedge sclk) begin
      mosi_cap <= {mosi_cap[6:0], mosi};
      rise_cnt <= rise_cnt + 3'd1;
   end
   assign miso = slave_byte[3'd7 - rise_cnt];

   int   hi_cycles = 0;
   int   cs_falls = 0;
   logic cs_prev = 1'b1;
   always @(negedge clk) begin
      if (sclk) hi_cycles++;
      if (cs_prev && !ss_n[0]) cs_falls++;
      cs_prev = ss_n[0];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [BUS_W-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [BUS_W-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_flag(input int b, input string req);
      logic [BUS_W-1:0] s;
      bit seen = 1'b0;
      for (int n = 0; n < 2000 && !seen; n++) begin
         bus_read(3'd2, s);
         seen = s[b];
      end
      chk(seen, req, "status flag timeout", 0, 1);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [BUS_W-1:0] r;
      int f0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      bus_read(3'd2, r); chk(r == 32'h60, "R11", "status", r, 32'h60);
      bus_read(3'd3, r); chk(r == 0, "R11", "control", r, 0);
      bus_read(3'd5, r); chk(r == 0, "R11", "select", r, 0);
      chk(&ss_n && !sclk && !irq, "R11", "ss_n/sclk/irq", {ss_n, sclk, irq}, {32'hFFFFFFFF, 2'b00});

      // R1 register map
      bus_write(3'd4, 32'hFFFFFFFF);
      bus_read(3'd4, r); chk(r == 0, "R1", "reserved", r, 0);
      bus_write(3'd3, 32'hFFFFFFFF);
      bus_read(3'd3, r); chk(r == 32'h5D8, "R1", "control mask", r, 32'h5D8);
      #1 chk(irq == 1'b1, "R8", "irq via TRDY enable", irq, 1);
      bus_write(3'd3, 32'h0);
      bus_write(3'd5, 32'h80000001);
      bus_read(3'd5, r); chk(r == 32'h80000001, "R1", "select readback", r, 32'h80000001);
      bus_write(3'd5, 32'h1);

      // vector table: R2 R3 R9
      for (int i = 0; i < NVEC; i++) begin
         logic [7:0] tb_tx = VEC[i][15:8];
         logic [7:0] tb_sb = VEC[i][7:0];
         slave_byte = tb_sb;
         hi_cycles = 0;
         f0 = cs_falls;
         bus_write(3'd1, {24'h0, tb_tx});
         wait_flag(7, "R3");
         bus_read(3'd0, r); chk(r == {24'h0, tb_sb}, "R3", "rx byte", r, tb_sb);
         chk(mosi_cap == tb_tx, "R2", "mosi byte", mosi_cap, tb_tx);
         chk(hi_cycles == 8 * CLK_DIV, "R2", "sclk high cycles", hi_cycles, 8 * CLK_DIV);
         chk(cs_falls == f0 + 1, "R9", "one select per frame", cs_falls - f0, 1);
         bus_read(3'd2, r); chk(r == 32'h60, "R3", "RRDY cleared", r, 32'h60);
      end

      // R4 receive overrun, R7 clear
      slave_byte = 8'h11;
      bus_write(3'd1, 32'h22);
      wait_flag(7, "R4");
      slave_byte = 8'h33;
      bus_write(3'd1, 32'h44);
      wait_flag(5, "R6");
      bus_read(3'd2, r); chk(r == 32'h1E8, "R4", "status with ROE/E", r, 32'h1E8);
      bus_read(3'd0, r); chk(r == 32'h33, "R4", "newer byte kept", r, 32'h33);
      bus_write(3'd2, 32'h0);
      bus_read(3'd2, r); chk(r == 32'h60, "R7", "flags cleared", r, 32'h60);

      // R5 transmit overrun, R6 TMT low while busy, R8 irq
      slave_byte = 8'h00;
      @(negedge clk);
      reg_addr = 3'd1; reg_wdata = 32'hC6; reg_wr = 1'b1;
      @(negedge clk);
      reg_wdata = 32'h39;
      @(negedge clk);
      reg_wr = 1'b0;
      bus_read(3'd2, r); chk(r == 32'h150, "R5", "TOE/E set, TMT low", r, 32'h150);
      chk(r[5] == 1'b0, "R6", "TMT low during frame", r[5], 0);
      bus_write(3'd3, 32'h10);
      #1 chk(irq == 1'b1, "R8", "irq on TOE", irq, 1);
      wait_flag(7, "R5");
      bus_read(3'd0, r);
      chk(mosi_cap == 8'hC6, "R5", "discarded write not sent", mosi_cap, 8'hC6);
      bus_write(3'd2, 32'h0);
      #1 chk(irq == 1'b0, "R8", "irq cleared", irq, 0);
      bus_write(3'd3, 32'h0);

      // R10 back-to-back without hold
      f0 = cs_falls;
      bus_write(3'd1, 32'h01);
      wait_flag(6, "R10");
      bus_write(3'd1, 32'h02);
      wait_flag(5, "R10");
      chk(cs_falls == f0 + 2, "R10", "select released between frames", cs_falls - f0, 2);
      bus_read(3'd0, r);
      chk(r == 32'h00, "R3", "second byte", r, 0);
      bus_write(3'd2, 32'h0);

      // R9 held select
      bus_write(3'd3, 32'h400);
      #1 chk(ss_n[0] == 1'b0, "R9", "held while idle", ss_n[0], 0);
      f0 = cs_falls;
      bus_write(3'd1, 32'h55);
      wait_flag(6, "R9");
      bus_write(3'd1, 32'hAA);
      wait_flag(5, "R9");
      chk(cs_falls == f0, "R9", "no release under hold", cs_falls - f0, 0);
      bus_read(3'd0, r);
      bus_write(3'd2, 32'h0);
      bus_write(3'd5, 32'h8);
      #1 chk(ss_n == ~32'h8, "R9", "line 3 only", ss_n, ~32'h8);
      bus_write(3'd5, 32'h0);
      #1 chk(&ss_n, "R9", "select zero", ss_n, 32'hFFFFFFFF);
      bus_write(3'd3, 32'h0);
      #1 chk(&ss_n, "R10", "hold cleared", ss_n, 32'hFFFFFFFF);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule